// File: doc/BRIEF.md
# Command Decoder with Self-Stepping Address Register

This block sits at the command-write port of a content-addressable memory. It takes 16-bit command words from a valid/ready stream and turns them into memory-access requests. Each request carries an opcode and a 10-bit word address on a second valid/ready stream. Bit 11 of a command word is the address flag. With the flag clear, the instruction runs at once at the address now held in the internal address register. With the flag set, the instruction is parked, and the next accepted command word is used as its address. The parked instruction then completes at that address.

Each time an access is issued, the address register is rewritten from the address that access used. It either steps up, steps down or keeps the value, as the two `addr_mode` pins select in that cycle. Command class `4'hA` (bits 15:12) is a register transfer into the address register. It produces no access. The memory array itself lies outside this block.

Back-pressure rules: a command word is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the single output slot is empty or is being drained in the same cycle (`!acc_valid || acc_ready`). This holds for every word class. While `acc_valid` is high and `acc_ready` is low, the request stays unchanged on the output.

Top module: `cam_cmd_seq`

## Requirements
- R1: While reset is held, and after it is released, `acc_valid` is 0 and `cmd_ready` is 1. The address register holds 0 and no instruction is pending.
- R2: An accepted word with bit 11 = 0 and a class (bits 15:12) other than `4'hA` issues exactly one access at the current address register value. `acc_valid` goes high the cycle after acceptance, and `acc_cmd` = {word[15:12], word[10:0]}.
- R3: An accepted word with bit 11 = 1 issues no access. `acc_valid` is 0 in the following cycle, and the word is held pending.
- R4: The accepted word that follows a pending instruction supplies the address in its bits 9:0, and its bits 15:10 are ignored. The pending instruction is issued at that address with `acc_cmd` built from the pending word as in R2. Only that one word is taken as an address, and the word after it is decoded as an instruction again.
- R5: When an access is issued, the address register becomes the issued address stepped by `addr_mode` as sampled in the issue cycle: `2'b01` adds 1, `2'b10` subtracts 1, and `2'b00` and `2'b11` keep it.
- R6: Stepping wraps: up from 1023 gives 0, and down from 0 gives 1023.
- R7: A class `4'hA` word with bit 11 = 0 loads bits 9:0 into the address register. With bit 11 = 1, the bits 9:0 of the next accepted word are loaded instead. Neither form issues an access, and a load does not step the register.
- R8: `cmd_ready` = `!acc_valid || acc_ready`. While `acc_valid` is 1 and `acc_ready` is 0, `acc_valid`, `acc_cmd` and `acc_addr` hold their values.
- R9: A reset that arrives while an instruction is pending cancels it. The first word after reset is decoded as an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_mode | input | 2 | Post-access step: 01 up, 10 down, 00/11 keep |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken |
| cmd_data | input | 16 | Command word; bit 11 is the address flag |
| acc_valid | output | 1 | Memory-access request present |
| acc_ready | input | 1 | Consumer takes the request |
| acc_cmd | output | 15 | Opcode: command word without bit 11 |
| acc_addr | output | 10 | Word address of the request |

## Verification
The bench drives the flagged two-word form with junk in the upper bits of the address word. It then checks that those bits are ignored and that the word after it is decoded as an instruction again. A decoder that held its capture state one word too long would issue accesses at addresses taken from opcodes. Stepping is exercised across both wrap points and in every mode, including the idle code 11. An off-by-one or a missing wrap would show up as a wrong next address. A reset is pulsed while an instruction is pending. A design that kept the pending state would take the first word after reset as an address and issue the stale opcode. Random output stalls test whether a request changes or is lost under back-pressure, and whether a command slips in while the slot is full.

// File: rtl/cam_cmd_pkg.sv
package cam_cmd_pkg;
  typedef enum logic [1:0] {
    STEP_KEEP  = 2'b00,
    STEP_UP    = 2'b01,
    STEP_DOWN  = 2'b10,
    STEP_KEEP2 = 2'b11
  } step_mode_e;

  typedef enum logic {
    DEC_IDLE,
    DEC_WAIT_ADDR
  } dec_state_e;

  // command class that moves a value into the address register
  localparam logic [3:0] CLS_LOAD_AR = 4'hA;
endpackage

// File: rtl/cam_cmd_addr_reg.sv
module cam_cmd_addr_reg
  import cam_cmd_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] step_base,
  input  step_mode_e        mode,
  output logic [ADDR_W-1:0] ar_q
);
  logic [ADDR_W-1:0] stepped;

  // natural modulo-2^ADDR_W arithmetic gives both wrap points
  always_comb begin
    case (mode)
      STEP_UP:   stepped = step_base + ADDR_W'(1);
      STEP_DOWN: stepped = step_base - ADDR_W'(1);
      default:   stepped = step_base;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0;
    end else if (load_en) begin
      ar_q <= load_val;
    end else if (step_en) begin
      ar_q <= stepped;
    end
  end
endmodule

// File: rtl/cam_cmd_decode.sv
module cam_cmd_decode
  import cam_cmd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int FLAG_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [DATA_W-1:0] data,
  input  logic [ADDR_W-1:0] ar_q,
  output logic              issue,
  output logic [DATA_W-2:0] issue_cmd,
  output logic [ADDR_W-1:0] issue_addr,
  output logic              load_en,
  output logic [ADDR_W-1:0] load_val
);
  localparam int CLS_W = DATA_W - FLAG_BIT - 1;
  localparam logic [CLS_W-1:0] LOAD_CLS = CLS_W'(CLS_LOAD_AR);

  dec_state_e        state_q;
  logic [DATA_W-1:0] pend_q;
  logic [DATA_W-1:0] issue_word;
  logic [CLS_W-1:0]  cls_in;
  logic [CLS_W-1:0]  cls_pend;
  logic              flag_in;

  assign cls_in   = data[DATA_W-1 -: CLS_W];
  assign cls_pend = pend_q[DATA_W-1 -: CLS_W];
  assign flag_in  = data[FLAG_BIT];

  always_comb begin
    issue      = 1'b0;
    load_en    = 1'b0;
    issue_word = data;
    issue_addr = ar_q;
    load_val   = data[ADDR_W-1:0];
    if (fire) begin
      if (state_q == DEC_WAIT_ADDR) begin
        // this word is the address of the parked instruction
        if (cls_pend == LOAD_CLS) begin
          load_en = 1'b1;
        end else begin
          issue      = 1'b1;
          issue_word = pend_q;
          issue_addr = data[ADDR_W-1:0];
        end
      end else if (!flag_in) begin
        if (cls_in == LOAD_CLS) begin
          load_en = 1'b1;
        end else begin
          issue = 1'b1;
        end
      end
    end
  end

  assign issue_cmd = {issue_word[DATA_W-1:FLAG_BIT+1], issue_word[FLAG_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DEC_IDLE;
      pend_q  <= '0;
    end else if (fire) begin
      if (state_q == DEC_IDLE && flag_in) begin
        state_q <= DEC_WAIT_ADDR;
        pend_q  <= data;
      end else begin
        state_q <= DEC_IDLE;
      end
    end
  end
endmodule

// File: rtl/cam_cmd_acc_slot.sv
module cam_cmd_acc_slot #(
  parameter int CMD_W  = 15,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [CMD_W-1:0]  cmd_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              space
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      cmd_q     <= '0;
      addr_q    <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      cmd_q     <= cmd_in;
      addr_q    <= addr_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_cmd_seq.sv
module cam_cmd_seq
  import cam_cmd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int FLAG_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              acc_valid,
  input  logic              acc_ready,
  output logic [DATA_W-2:0] acc_cmd,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int CMD_W = DATA_W - 1;

  logic              fire;
  logic              issue;
  logic [CMD_W-1:0]  issue_cmd;
  logic [ADDR_W-1:0] issue_addr;
  logic              load_en;
  logic [ADDR_W-1:0] load_val;
  logic [ADDR_W-1:0] ar_q;
  logic              space;

  assign cmd_ready = space;
  assign fire      = cmd_valid && space;

  cam_cmd_decode #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
  ) u_decode (
    .clk(clk), .rst_n(rst_n), .fire(fire), .data(cmd_data), .ar_q(ar_q),
    .issue(issue), .issue_cmd(issue_cmd), .issue_addr(issue_addr),
    .load_en(load_en), .load_val(load_val)
  );

  cam_cmd_addr_reg #(.ADDR_W(ADDR_W)) u_ar (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .step_en(issue), .step_base(issue_addr),
    .mode(step_mode_e'(addr_mode)), .ar_q(ar_q)
  );

  cam_cmd_acc_slot #(.CMD_W(CMD_W), .ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .load(issue), .cmd_in(issue_cmd),
    .addr_in(issue_addr), .out_ready(acc_ready), .out_valid(acc_valid),
    .cmd_q(acc_cmd), .addr_q(acc_addr), .space(space)
  );
endmodule

// File: rtl/cam_cmd_seq_chk.sv
module cam_cmd_seq_chk #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 10,
  parameter int FLAG_BIT = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        addr_mode,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_data,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [DATA_W-2:0] acc_cmd,
  input logic [ADDR_W-1:0] acc_addr
);
  localparam int CLS_W = DATA_W - FLAG_BIT - 1;
  localparam logic [CLS_W-1:0] LOAD_CLS = CLS_W'(4'hA);

  logic              fire;
  logic              chk_pend;
  logic [CLS_W-1:0]  chk_cls;
  logic [DATA_W-1:0] data_q;
  logic [CLS_W-1:0]  cls_in;

  assign fire   = cmd_valid && cmd_ready;
  assign cls_in = cmd_data[DATA_W-1 -: CLS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_pend <= 1'b0;
      chk_cls  <= '0;
      data_q   <= '0;
    end else begin
      data_q <= cmd_data;
      if (fire) begin
        chk_pend <= !chk_pend && cmd_data[FLAG_BIT];
        if (!chk_pend) chk_cls <= cls_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!acc_valid && cmd_ready);
    end
  end

  p_empty_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> cmd_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_ready |=> acc_valid && $stable(acc_cmd) && $stable(acc_addr));

  p_flag_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !chk_pend && cmd_data[FLAG_BIT] |=> !acc_valid);

  p_addr_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && chk_pend && chk_cls != LOAD_CLS |=> acc_valid && acc_addr == data_q[ADDR_W-1:0]);

  p_load_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !chk_pend && !cmd_data[FLAG_BIT] && cls_in == LOAD_CLS |=> !acc_valid);

  p_direct_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !chk_pend && !cmd_data[FLAG_BIT] && cls_in != LOAD_CLS |=>
      acc_valid && acc_cmd == {data_q[DATA_W-1:FLAG_BIT+1], data_q[FLAG_BIT-1:0]});

  // mode pins are free-running; they must never be unknown once out of reset (R5)
  p_mode_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(addr_mode));
endmodule

bind cam_cmd_seq cam_cmd_seq_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .FLAG_BIT(FLAG_BIT)
) u_chk (.*);

// File: tb/cam_cmd_seq_bench.sv
`timescale 1ns/1ps
module cam_cmd_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr_mode = 2'b00;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = 16'h0;
  logic        acc_valid;
  logic        acc_ready = 1'b1;
  logic [14:0] acc_cmd;
  logic [9:0]  acc_addr;

  always #10 clk = ~clk;

  cam_cmd_seq u_cam_cmd_seq (
    .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .acc_valid(acc_valid),
    .acc_ready(acc_ready), .acc_cmd(acc_cmd), .acc_addr(acc_addr)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  bit        m_valid = 0;
  bit        m_pend = 0;
  bit        m_src = 0;
  int        m_ar = 0;
  int        m_addr = 0;
  logic [14:0] m_cmd = '0;
  logic [15:0] m_pw = '0;

  // observed handshakes at the output
  int        hs_cnt = 0;
  int        last_addr = -1;
  logic [14:0] last_cmd = '0;

  function automatic logic [14:0] mk(input logic [15:0] w);
    return {w[15:12], w[10:0]};
  endfunction

  function automatic int step(input int a, input logic [1:0] m);
    if (m == 2'b01) return (a + 1) % 1024;
    if (m == 2'b10) return (a + 1023) % 1024;
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_issue(input logic [15:0] w, input int a, input bit src);
    m_valid = 1;
    m_cmd   = mk(w);
    m_addr  = a;
    m_src   = src;
    m_ar    = step(a, addr_mode);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_pend = 0; m_ar = 0;
    end else begin
      bit fire_e;
      logic [15:0] w;
      fire_e = cmd_valid && (!m_valid || acc_ready);
      if (m_valid && acc_ready) m_valid = 0;
      if (fire_e) begin
        w = cmd_data;
        if (m_pend) begin
          m_pend = 0;
          if (m_pw[15:12] == 4'hA) m_ar = int'(w[9:0]);
          else model_issue(m_pw, int'(w[9:0]), 1);
        end else if (w[11]) begin
          m_pend = 1; m_pw = w;
        end else if (w[15:12] == 4'hA) begin
          m_ar = int'(w[9:0]);
        end else begin
          model_issue(w, m_ar, 0);
        end
      end
    end
    if (rst_n && acc_valid && acc_ready) begin
      hs_cnt++;
      last_addr = int'(acc_addr);
      last_cmd  = acc_cmd;
    end
  end

  // drive output ready, then compare with the model every cycle
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rdy_mode)
      0: acc_ready = 1'b1;
      1: acc_ready = lfsr[0] | lfsr[3];
      default: acc_ready = 1'b0;
    endcase
    #1;
    if (!done) begin
      chk(acc_valid == m_valid, "R8 valid", acc_valid, m_valid);
      chk(cmd_ready == (!m_valid || acc_ready), "R8 ready", cmd_ready, !m_valid || acc_ready);
      if (m_valid && acc_valid) begin
        chk(acc_cmd == m_cmd, m_src ? "R4 cmd" : "R2 cmd", acc_cmd, m_cmd);
        chk(int'(acc_addr) == m_addr, m_src ? "R4 addr" : "R5 addr", acc_addr, m_addr);
      end
    end
  end

  task automatic send(input logic [15:0] w);
    @(negedge clk); #3;
    cmd_valid = 1'b1; cmd_data = w;
    #1;
    while (!cmd_ready) begin
      @(negedge clk); #4;
    end
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); #3; addr_mode = m;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic pulse_reset();
    @(negedge clk); #3; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #3; rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    #2;
    chk(!acc_valid && cmd_ready, "R1 in reset", {acc_valid, cmd_ready}, 2'b01);
    #1; rst_n = 1'b1;
    settle();
    chk(!acc_valid && cmd_ready, "R1 after reset", {acc_valid, cmd_ready}, 2'b01);
    send(16'h1000); settle();
    chk(last_addr == 0, "R1 address zero", last_addr, 0);

    // R7 load then R2 direct instruction at the loaded address
    h0 = hs_cnt;
    send(16'hA005); settle();
    chk(hs_cnt == h0, "R7 load no access", hs_cnt, h0);
    send(16'h3123); settle();
    chk(last_cmd == 15'h1923, "R2 opcode", last_cmd, 15'h1923);
    chk(last_addr == 5, "R2 address", last_addr, 5);

    // R5 stepping modes
    set_mode(2'b01);
    send(16'h1000); send(16'h1000); settle();
    chk(last_addr == 6, "R5 increment", last_addr, 6);
    set_mode(2'b10);
    send(16'h1000); send(16'h1000); settle();
    chk(last_addr == 6, "R5 decrement", last_addr, 6);
    set_mode(2'b11);
    send(16'h1000); send(16'h1000); settle();
    chk(last_addr == 5, "R5 keep code 11", last_addr, 5);

    // R6 wrap points
    set_mode(2'b01);
    send(16'hA3FF); send(16'h1000); send(16'h1000); settle();
    chk(last_addr == 0, "R6 wrap up", last_addr, 0);
    set_mode(2'b10);
    send(16'hA000); send(16'h1000); send(16'h1000); settle();
    chk(last_addr == 1023, "R6 wrap down", last_addr, 1023);

    // R3 deferral and R4 address word
    set_mode(2'b00);
    h0 = hs_cnt;
    send(16'h5900);
    @(negedge clk); #2;
    chk(!acc_valid, "R3 deferred", acc_valid, 0);
    chk(hs_cnt == h0, "R3 no access", hs_cnt, h0);
    send(16'hFC21); settle();
    chk(last_addr == 16'h021, "R4 address bits", last_addr, 16'h021);
    chk(last_cmd == 15'h2900, "R4 parked opcode", last_cmd, 15'h2900);
    send(16'h6000); settle();
    chk(last_cmd == 15'h3000 && last_addr == 16'h021, "R4 one word only", last_addr, 16'h021);

    // R7 flagged load
    h0 = hs_cnt;
    send(16'hA800); send(16'h0123); settle();
    chk(hs_cnt == h0, "R7 flagged load no access", hs_cnt, h0);
    send(16'h3000); settle();
    chk(last_addr == 16'h123, "R7 flagged load value", last_addr, 16'h123);

    // R8 stall
    rdy_mode = 2;
    send(16'h1000);
    repeat (3) @(negedge clk);
    #2;
    chk(acc_valid && !cmd_ready, "R8 stall", {acc_valid, cmd_ready}, 2'b10);
    rdy_mode = 0;
    settle();

    // R9 reset while pending
    send(16'h2800);
    pulse_reset();
    send(16'h1005); settle();
    chk(last_addr == 0, "R9 cancel address", last_addr, 0);
    chk(last_cmd == 15'h0805, "R9 cancel opcode", last_cmd, 15'h0805);

    // random traffic under random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 600; i++) begin
      if (i % 7 == 0) set_mode(2'($urandom));
      send(16'($urandom));
    end
    rdy_mode = 0;
    settle();
    finish_run();
  end
endmodule